// File: doc/BRIEF.md
# Expansion-Channel DRAM Refresh Sequencer

This block keeps dynamic memory on a parallel expansion channel alive. An interval timer produces refresh credits. The block turns each credit into one read-type bus cycle, during which an active-low refresh flag is driven and a 9-bit refresh address is presented. A separate bus sequencer carries out the cycle and signals its end with a one-clock done pulse. A refresh cycle may begin only while the channel's arbitration line is in its arbitrate phase.

Credits that cannot be served right away, because arbitration is not in the arbitrate phase, are banked in a small saturating counter. They are paid back later as a burst of cycles. After reset the block runs a start-up burst of 64 refreshes at the fast rate, which memory needs before it can be used. It then raises a done flag and switches to the rate that the active-low select bit asks for: fast when the bit is 0, normal when it is 1.

The controller has three states:
- `ST_IDLE`: no cycle is requested.
- `ST_ARB_WAIT`: a request is raised and the block waits for the arbitrate phase.
- `ST_CYCLE`: a refresh cycle is on the channel.

The transitions are:
- IDLE→ARB_WAIT when at least one credit is banked.
- ARB_WAIT→CYCLE on a clock edge that samples `arb_phase`=1. This consumes one credit.
- CYCLE→IDLE on a clock edge that samples `cyc_done`=1. This advances the address.

Top module: `memrefresh_ctrl`

## Requirements
- R1: After reset, `rfsh_req`=0, `rfsh_n`=1, `rfsh_addr`=0 and `init_done`=0.
- R2: Each completed refresh cycle advances `rfsh_addr` by exactly one, modulo 512. Bit 0 toggles on every completion and 511 wraps to 0.
- R3: `rfsh_addr` holds steady for the whole time `rfsh_n` is low.
- R4: A refresh cycle (`rfsh_n` falling) starts only on the clock after an edge that sampled `arb_phase`=1 while `rfsh_req` was high. `rfsh_req` stays high until that edge.
- R5: After start-up, `rate_sel_n`=1 produces one credit every SLOW_CLKS clocks and `rate_sel_n`=0 produces one every FAST_CLKS clocks.
- R6: Banked credits saturate at PEND_MAX (4). Credits held back by a non-arbitrate phase are paid back as consecutive refresh cycles.
- R7: Until INIT_COUNT (64) cycles have completed, credits come every FAST_CLKS clocks whatever `rate_sel_n` is. `init_done` rises on the edge that completes the 64th cycle and stays high.
- R8: `rfsh_n` is low from the edge after the start until the edge that samples `cyc_done`=1. The block then spends at least one clock in `ST_IDLE` before the next request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rate_sel_n | input | 1 | Rate select bit, active low: 0 = fast, 1 = normal |
| arb_phase | input | 1 | 1 while the arbitration line is in the arbitrate phase |
| cyc_done | input | 1 | Pulse from the bus sequencer that ends the current refresh cycle |
| rfsh_req | output | 1 | Refresh cycle requested and waiting for the arbitrate phase |
| rfsh_n | output | 1 | Refresh cycle in progress, active low |
| rfsh_addr | output | 9 | Refresh row/byte address |
| init_done | output | 1 | Start-up burst of refreshes complete |

## Verification
A timer expiry at edge N banks a credit on that same edge. `rfsh_req` then rises one edge later, at N+1. An edge that samples `arb_phase`=1 drops `rfsh_req` and lowers `rfsh_n` on that edge. An edge that samples `cyc_done` raises `rfsh_n` and steps `rfsh_addr` together.

The bench keeps a behavioural per-edge model of the timer, the credit count and the state. It updates the model on each rising edge from the inputs sampled there. It compares all four outputs at the following falling edge, which is after every register has settled and before new inputs are driven.

The stimulus covers the start-up burst, both rates, a long non-arbitrate stretch that saturates the credit count, and a toggling arbitrate phase with varied done delays. It runs through an address wrap.

// File: rtl/memrefresh_pkg.sv
package memrefresh_pkg;
    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_ARB_WAIT = 2'd1,
        ST_CYCLE    = 2'd2
    } rfsh_state_e;
endpackage

// File: rtl/rfsh_interval_timer.sv
// Free-running interval timer; emits one tick per selected period.
module rfsh_interval_timer #(
    parameter int FAST_CLKS = 6,
    parameter int SLOW_CLKS = 40
) (
    input  logic clk,
    input  logic rst_n,
    input  logic use_slow,
    output logic tick
);
    localparam int MAXP = (SLOW_CLKS > FAST_CLKS) ? SLOW_CLKS : FAST_CLKS;
    localparam int TW   = $clog2(MAXP + 1);

    logic [TW-1:0] cnt;
    logic [TW-1:0] limit;

    always_comb begin
        limit = use_slow ? TW'(SLOW_CLKS - 1) : TW'(FAST_CLKS - 1);
        tick  = (cnt >= limit);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    cnt <= '0;
        else if (tick) cnt <= '0;
        else           cnt <= cnt + 1'b1;
    end

    // R5: with periods of at least two clocks, ticks never come back to back
    assert_tick_gap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
endmodule

// File: rtl/rfsh_credit_counter.sv
// Saturating bank of refresh credits not yet turned into bus cycles.
module rfsh_credit_counter #(
    parameter int PEND_MAX = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic add,
    input  logic take,
    output logic any
);
    localparam int CW = $clog2(PEND_MAX + 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (add && !take) begin
            if (cnt != CW'(PEND_MAX)) cnt <= cnt + 1'b1;
        end else if (take && !add) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign any = (cnt != '0);

    // R6: a cycle never starts without a banked credit
    assert_take_has_credit_R6: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> (cnt != '0));
    // R6: the bank holds at its ceiling instead of wrapping
    assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == CW'(PEND_MAX) && add && !take) |=> (cnt == CW'(PEND_MAX)));
endmodule

// File: rtl/rfsh_progress.sv
// Refresh address counter and start-up burst tracker.
module rfsh_progress #(
    parameter int ADDR_W     = 9,
    parameter int INIT_COUNT = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step,
    output logic [ADDR_W-1:0] addr,
    output logic              init_done
);
    localparam int IW = $clog2(INIT_COUNT + 1);

    logic [IW-1:0] init_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr     <= '0;
            init_cnt <= '0;
        end else if (step) begin
            addr <= addr + 1'b1;
            if (init_cnt != IW'(INIT_COUNT)) init_cnt <= init_cnt + 1'b1;
        end
    end

    assign init_done = (init_cnt == IW'(INIT_COUNT));

    // R7: once the start-up burst is complete it stays complete
    assert_init_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |=> init_done);
    // R2: each completed cycle moves the address by exactly one
    assert_addr_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        step |=> (addr == ADDR_W'($past(addr) + 1'b1)));
endmodule

// File: rtl/memrefresh_ctrl.sv
// Refresh cycle sequencer for DRAM on a parallel expansion channel.
module memrefresh_ctrl #(
    parameter int FAST_CLKS  = 6,
    parameter int SLOW_CLKS  = 40,
    parameter int PEND_MAX   = 4,
    parameter int INIT_COUNT = 64,
    parameter int ADDR_W     = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rate_sel_n,
    input  logic              arb_phase,
    input  logic              cyc_done,
    output logic              rfsh_req,
    output logic              rfsh_n,
    output logic [ADDR_W-1:0] rfsh_addr,
    output logic              init_done
);
    import memrefresh_pkg::*;

    rfsh_state_e state_q, state_d;
    logic        tick;
    logic        any_credit;
    logic        start_cyc;
    logic        end_cyc;
    logic        use_slow;

    // Fast rate during start-up, then the register bit decides.
    assign use_slow  = init_done & rate_sel_n;
    assign start_cyc = (state_q == ST_ARB_WAIT) && arb_phase;
    assign end_cyc   = (state_q == ST_CYCLE) && cyc_done;

    rfsh_interval_timer #(
        .FAST_CLKS (FAST_CLKS),
        .SLOW_CLKS (SLOW_CLKS)
    ) timer_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .use_slow (use_slow),
        .tick     (tick)
    );

    rfsh_credit_counter #(
        .PEND_MAX (PEND_MAX)
    ) credit_i (
        .clk   (clk),
        .rst_n (rst_n),
        .add   (tick),
        .take  (start_cyc),
        .any   (any_credit)
    );

    rfsh_progress #(
        .ADDR_W     (ADDR_W),
        .INIT_COUNT (INIT_COUNT)
    ) prog_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .step      (end_cyc),
        .addr      (rfsh_addr),
        .init_done (init_done)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:     if (any_credit) state_d = ST_ARB_WAIT;
            ST_ARB_WAIT: if (arb_phase)  state_d = ST_CYCLE;
            ST_CYCLE:    if (cyc_done)   state_d = ST_IDLE;
            default:                     state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Moore outputs
    always_comb begin
        rfsh_req = 1'b0;
        rfsh_n   = 1'b1;
        unique case (state_q)
            ST_IDLE:     ;
            ST_ARB_WAIT: rfsh_req = 1'b1;
            ST_CYCLE:    rfsh_n   = 1'b0;
            default:     ;
        endcase
    end

    // R3: the address does not move while the refresh flag is low
    assert_addr_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!rfsh_n && !cyc_done) |=> $stable(rfsh_addr));
    // R4: a cycle starts only after an edge that saw the arbitrate phase
    assert_start_in_arb_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rfsh_n) |-> ($past(arb_phase) && $past(rfsh_req)));
    // R8: after a cycle ends, no request or cycle on the next clock
    assert_idle_gap_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rfsh_n) |-> (!rfsh_req && rfsh_n));
    // R4: request and cycle flags are never active together
    assert_req_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(rfsh_req && !rfsh_n));
endmodule

// File: tb/memrefresh_ctrl_tb_top.sv
module memrefresh_ctrl_tb_top;
    localparam int FAST = 6;
    localparam int SLOW = 40;
    localparam int PMAX = 4;
    localparam int INIT = 64;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rate_sel_n = 1'b1;
    logic       arb_phase = 1'b0;
    logic       cyc_done = 1'b0;
    logic       rfsh_req;
    logic       rfsh_n;
    logic [8:0] rfsh_addr;
    logic       init_done;

    int checks = 0;
    int errors = 0;

    // behavioural reference state
    int  m_tcnt, m_pend, m_state, m_addr, m_ncomp;
    bit  m_wrapped;
    int  wcnt, dly, arb_mode, cyc;
    int  slow_done, fast_done;

    always #5 clk = ~clk;

    memrefresh_ctrl #(
        .FAST_CLKS (FAST), .SLOW_CLKS (SLOW), .PEND_MAX (PMAX),
        .INIT_COUNT (INIT), .ADDR_W (9)
    ) dut_i (
        .clk (clk), .rst_n (rst_n), .rate_sel_n (rate_sel_n),
        .arb_phase (arb_phase), .cyc_done (cyc_done),
        .rfsh_req (rfsh_req), .rfsh_n (rfsh_n),
        .rfsh_addr (rfsh_addr), .init_done (init_done)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s at cycle %0d: actual %0d expected %0d", req, cyc, act, exp);
        end
    endtask

    // state codes of the model: 0 idle, 1 waiting for arbitrate, 2 in cycle
    task automatic model_step();
        int  per;
        bit  tick, start, fin, mdone;
        mdone = (m_ncomp >= INIT);
        per   = (mdone && rate_sel_n) ? SLOW : FAST;   // R5 / R7 rates
        tick  = (m_tcnt >= per - 1);
        start = (m_state == 1) && arb_phase;
        fin   = (m_state == 2) && cyc_done;
        m_tcnt = tick ? 0 : m_tcnt + 1;
        if (tick && !start)      m_pend = (m_pend < PMAX) ? m_pend + 1 : PMAX;
        else if (start && !tick) m_pend = m_pend - 1;
        case (m_state)
            0: if (m_pend_prev_nz) m_state = 1;
            1: if (arb_phase) m_state = 2;
            default: if (cyc_done) m_state = 0;
        endcase
        if (fin) begin
            if (m_addr == 511) m_wrapped = 1'b1;
            m_addr = (m_addr + 1) % 512;
            m_ncomp++;
            if (rate_sel_n && mdone) slow_done++;
            if (!rate_sel_n && mdone) fast_done++;
        end
    endtask
    bit m_pend_prev_nz;

    task automatic compare();
        chk("R4 rfsh_req", int'(rfsh_req), int'(m_state == 1));
        chk("R8 rfsh_n", int'(rfsh_n), int'(m_state != 2));
        chk("R2/R3 rfsh_addr", int'(rfsh_addr), m_addr);
        chk("R7 init_done", int'(init_done), int'(m_ncomp >= INIT));
    endtask

    task automatic drive();
        if (!rfsh_n) begin
            cyc_done = (wcnt >= dly);
            wcnt++;
        end else begin
            cyc_done = 1'b0;
            wcnt = 0;
        end
        case (arb_mode)
            0: arb_phase = 1'b1;
            1: arb_phase = 1'b0;
            default: arb_phase = (cyc % 3) != 0;
        endcase
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            cyc++;
            m_pend_prev_nz = (m_pend != 0);
            model_step();
            @(negedge clk);
            compare();
            drive();
        end
    endtask

    initial begin
        int sd, fd;
        m_tcnt = 0; m_pend = 0; m_state = 0; m_addr = 0; m_ncomp = 0;
        m_wrapped = 0; wcnt = 0; dly = 1; arb_mode = 0; cyc = 0;
        slow_done = 0; fast_done = 0;
        repeat (3) @(negedge clk);
        // R1: reset values
        chk("R1 rfsh_req", int'(rfsh_req), 0);
        chk("R1 rfsh_n", int'(rfsh_n), 1);
        chk("R1 rfsh_addr", int'(rfsh_addr), 0);
        chk("R1 init_done", int'(init_done), 0);
        rst_n = 1'b1;
        arb_phase = 1'b1;
        // R7: start-up burst runs at the fast rate though the bit asks for slow
        run(INIT * FAST + 100);
        chk("R7 burst finished", int'(init_done), 1);
        // R5: normal rate
        sd = slow_done;
        run(800);
        chk("R5 slow count", slow_done - sd, 20);
        // R5: fast rate
        rate_sel_n = 1'b0;
        run(12);
        fd = fast_done;
        run(600);
        chk("R5 fast count", fast_done - fd, 100);
        // R6: hold off arbitration to saturate the bank, then release
        arb_mode = 1;
        run(300);
        chk("R6 held off", int'(rfsh_n), 1);
        arb_mode = 0;
        dly = 0;
        run(200);
        // R4/R3: toggling arbitrate phase and varied done delays until a wrap
        arb_mode = 2;
        for (int d = 0; d < 4; d++) begin
            dly = d;
            run(1200);
        end
        chk("R2 address wrapped", int'(m_wrapped), 1);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired at cycle %0d: actual 0 expected 1", cyc);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule